// File: doc/BRIEF.md
# Multi-Lane PHY Reset and Calibration Sequencer

This block runs the bring-up sequences of a multi-lane serial PHY from a single start pulse. A lane mask of up to 24 bits says which lanes take part. Three sequences are offered: a lane reset that also loads fixed per-lane settings, a receive DC calibration followed by a transmit FIFO init, and receive training. Each step drives per-lane control levels or one-cycle strobes toward the PHY. Where a sequence must wait, it waits on the PHY's per-lane status bits, reduced over the enabled lanes only.

A controller raises `start` for one cycle with `seq_sel` and `lane_mask` valid. The block holds `seq_busy` until it finishes and then pulses `seq_done` for one cycle. The mask is captured at start, so later changes on `lane_mask` do not affect a sequence that is already running. All pins are plain control and status signals; there is no streaming data path.

Top module: `lane_cal_seq`

## Requirements
- R1: Out of reset, `clk_pdwn` is 1, `lane_pdwn` and `unload_off` are all ones, all other lane outputs are 0, and `seq_busy` and `seq_done` are 0.
- R2: For `seq_sel`=0 (lane reset), one cycle after start `clk_pdwn` is 0, and `run_lane` is cleared on the enabled lanes and unchanged on the others.
- R3: The lane reset sequence stays in its wait step while any enabled lane has `lane_busy` set. `lane_busy` on lanes outside the mask has no effect.
- R4: One cycle after the wait ends, `rx_io_rst` and `tx_io_rst` are high on the enabled lanes for exactly one cycle. One cycle after they fall, `rot_rst` pulses high for one cycle.
- R5: In the cycle after the `rot_rst` pulse, `cfg_load` strobes on the enabled lanes and their `lane_pdwn` bits clear. The setting outputs hold IQ select 7, phase step 0xC, inertia 4, LTE 3 and coarse gain 11.
- R6: For `seq_sel`=1 (DC calibration), `fw_off` is set on the enabled lanes one cycle after start and `run_cal` one cycle later. The sequence then waits until every enabled lane reports `cal_done`.
- R7: One cycle after the wait ends, `run_cal` clears. In the following cycle `cal_clr` strobes on the enabled lanes and `fw_off` clears.
- R8: After the calibration tail, `unload_off` clears on the enabled lanes. One cycle later `fifo_init` pulses for one cycle. In the next cycle `unload_off` is set again. `fifo_init` is never high on a lane whose unload clock is off.
- R9: For `seq_sel`=2 (training), `run_lane` is set on the enabled lanes one cycle after start. The sequence finishes two cycles after every enabled lane shows `train_done`.
- R10: `seq_busy` is high from the cycle after start until the sequence ends. `seq_done` is a single-cycle pulse in the first cycle with `seq_busy` low.
- R11: A start with an all-zero mask, or with `seq_sel`=3, pulses `seq_done` in the next cycle and changes no lane output.
- R12: A start while `seq_busy` is high is ignored. Changes to `lane_mask` during a sequence do not alter which lanes it drives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to run a sequence |
| seq_sel | input | 2 | 0 lane reset, 1 DC calibration and FIFO init, 2 training, 3 none |
| lane_mask | input | 24 | Enabled lanes, sampled at start |
| lane_busy | input | 24 | Per-lane busy status from PHY |
| cal_done | input | 24 | Per-lane DC calibration done |
| train_done | input | 24 | Per-lane training init done |
| seq_busy | output | 1 | Sequence in progress |
| seq_done | output | 1 | One-cycle completion pulse |
| clk_pdwn | output | 1 | Shared receive/transmit clock distribution power-down |
| run_lane | output | 24 | Per-lane run level |
| rx_io_rst | output | 24 | Receive I/O reset |
| tx_io_rst | output | 24 | Transmit I/O reset |
| rot_rst | output | 24 | Phase rotator reset strobe |
| cfg_load | output | 24 | Strobe to load the fixed lane settings |
| lane_pdwn | output | 24 | Analog, digital and transmit lane power-down |
| fw_off | output | 24 | Flywheel disable |
| run_cal | output | 24 | Run DC calibration |
| cal_clr | output | 24 | Strobe clearing bank controls and edge-track control |
| unload_off | output | 24 | Transmit unload clock disable |
| fifo_init | output | 24 | Transmit FIFO init strobe |
| cfg_iq_sel | output | 3 | Phase rotator IQ select value |
| cfg_phase_step | output | 4 | Phase step value |
| cfg_inertia | output | 3 | Flywheel inertia value |
| cfg_lte | output | 4 | LTE setting |
| cfg_gain | output | 4 | Integrator coarse gain for all three integrators |

## Verification
Every action step is one register stage. A result is due an exact number of cycles after the edge that samples `start`, or after the edge that first sees a wait condition met: 1 for the first action, and one more for each later step. Inputs are driven and outputs read on falling edges. Each test task walks the sequence one falling edge at a time and compares every step's outputs in its due cycle. During wait steps, the next step's outputs are shown to stay quiet, and status on lanes outside the mask is held active to show it is ignored.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
  typedef enum logic [3:0] {
    A_NONE, A_RST_BEGIN, A_IO_SET, A_IO_CLR, A_ROT, A_LOAD,
    A_FW_OFF, A_CAL_RUN, A_CAL_STOP, A_CAL_CLR,
    A_UNLD_ON, A_FIFO, A_UNLD_OFF, A_TRAIN
  } act_e;

  typedef enum logic [3:0] {
    S_IDLE, S_RWAIT, S_RIOCLR, S_RROT, S_RLOAD,
    S_DRUN, S_DWAIT, S_DCLR, S_FON, S_FINIT, S_FOFF,
    S_TWAIT, S_FIN
  } st_e;

  localparam logic [2:0] IQ_SEL_VAL   = 3'd7;
  localparam logic [3:0] PH_STEP_VAL  = 4'hC;
  localparam logic [2:0] INERTIA_VAL  = 3'd4;
  localparam logic [3:0] LTE_VAL      = 4'd3;
  localparam logic [3:0] GAIN_VAL     = 4'd11;
endpackage

// File: rtl/lcs_mask_reduce.sv
module lcs_mask_reduce #(
  parameter int LANES = 24
) (
  input  logic [LANES-1:0] mask,
  input  logic [LANES-1:0] busy_in,
  input  logic [LANES-1:0] cal_in,
  input  logic [LANES-1:0] train_in,
  output logic             any_busy,
  output logic             all_cal,
  output logic             all_train
);
  logic [LANES-1:0] busy_t, cal_miss, train_miss;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign busy_t[i]     = mask[i] & busy_in[i];
    assign cal_miss[i]   = mask[i] & ~cal_in[i];
    assign train_miss[i] = mask[i] & ~train_in[i];
  end

  assign any_busy  = |busy_t;
  assign all_cal   = ~|cal_miss;
  assign all_train = ~|train_miss;
endmodule

// File: rtl/lcs_ctrl.sv
module lcs_ctrl
  import lcs_pkg::*;
#(
  parameter int LANES = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       seq_sel,
  input  logic [LANES-1:0] lane_mask,
  input  logic             any_busy,
  input  logic             all_cal,
  input  logic             all_train,
  output act_e             act,
  output logic [LANES-1:0] act_mask,
  output logic             busy,
  output logic             done
);
  st_e st, nxt;
  logic fin;
  logic [LANES-1:0] mask_q;

  assign busy     = (st != S_IDLE);
  assign act_mask = (st == S_IDLE) ? lane_mask : mask_q;

  always_comb begin
    nxt = st;
    act = A_NONE;
    fin = 1'b0;
    case (st)
      S_IDLE: if (start) begin
        if (lane_mask == '0 || seq_sel == 2'd3) fin = 1'b1;
        else if (seq_sel == 2'd0) begin act = A_RST_BEGIN; nxt = S_RWAIT; end
        else if (seq_sel == 2'd1) begin act = A_FW_OFF;    nxt = S_DRUN;  end
        else                      begin act = A_TRAIN;     nxt = S_TWAIT; end
      end
      S_RWAIT:  if (!any_busy) begin act = A_IO_SET; nxt = S_RIOCLR; end
      S_RIOCLR: begin act = A_IO_CLR;   nxt = S_RROT;  end
      S_RROT:   begin act = A_ROT;      nxt = S_RLOAD; end
      S_RLOAD:  begin act = A_LOAD;     nxt = S_FIN;   end
      S_DRUN:   begin act = A_CAL_RUN;  nxt = S_DWAIT; end
      S_DWAIT:  if (all_cal) begin act = A_CAL_STOP; nxt = S_DCLR; end
      S_DCLR:   begin act = A_CAL_CLR;  nxt = S_FON;   end
      S_FON:    begin act = A_UNLD_ON;  nxt = S_FINIT; end
      S_FINIT:  begin act = A_FIFO;     nxt = S_FOFF;  end
      S_FOFF:   begin act = A_UNLD_OFF; nxt = S_FIN;   end
      S_TWAIT:  if (all_train) nxt = S_FIN;
      S_FIN:    begin fin = 1'b1; nxt = S_IDLE; end
      default:  nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      done   <= 1'b0;
      mask_q <= '0;
    end else begin
      st   <= nxt;
      done <= fin;
      if (st == S_IDLE && start) mask_q <= lane_mask;
    end
  end

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_wait_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RWAIT && any_busy) |=> (st == S_RWAIT));
  assert_train_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TWAIT && !all_train) |=> !done);
endmodule

// File: rtl/lcs_lane_regs.sv
module lcs_lane_regs
  import lcs_pkg::*;
#(
  parameter int LANES = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  act_e             act,
  input  logic [LANES-1:0] m,
  output logic             clk_pdwn,
  output logic [LANES-1:0] run_lane,
  output logic [LANES-1:0] rx_io_rst,
  output logic [LANES-1:0] tx_io_rst,
  output logic [LANES-1:0] rot_rst,
  output logic [LANES-1:0] cfg_load,
  output logic [LANES-1:0] lane_pdwn,
  output logic [LANES-1:0] fw_off,
  output logic [LANES-1:0] run_cal,
  output logic [LANES-1:0] cal_clr,
  output logic [LANES-1:0] unload_off,
  output logic [LANES-1:0] fifo_init
);
  localparam logic [LANES-1:0] ALL1 = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_pdwn   <= 1'b1;
      run_lane   <= '0;
      rx_io_rst  <= '0;
      tx_io_rst  <= '0;
      rot_rst    <= '0;
      cfg_load   <= '0;
      lane_pdwn  <= ALL1;
      fw_off     <= '0;
      run_cal    <= '0;
      cal_clr    <= '0;
      unload_off <= ALL1;
      fifo_init  <= '0;
    end else begin
      rot_rst   <= (act == A_ROT)     ? m : '0;
      cfg_load  <= (act == A_LOAD)    ? m : '0;
      cal_clr   <= (act == A_CAL_CLR) ? m : '0;
      fifo_init <= (act == A_FIFO)    ? m : '0;
      case (act)
        A_RST_BEGIN: begin clk_pdwn <= 1'b0; run_lane <= run_lane & ~m; end
        A_IO_SET:    begin rx_io_rst <= rx_io_rst | m;  tx_io_rst <= tx_io_rst | m;  end
        A_IO_CLR:    begin rx_io_rst <= rx_io_rst & ~m; tx_io_rst <= tx_io_rst & ~m; end
        A_LOAD:      lane_pdwn  <= lane_pdwn & ~m;
        A_FW_OFF:    fw_off     <= fw_off | m;
        A_CAL_RUN:   run_cal    <= run_cal | m;
        A_CAL_STOP:  run_cal    <= run_cal & ~m;
        A_CAL_CLR:   fw_off     <= fw_off & ~m;
        A_UNLD_ON:   unload_off <= unload_off & ~m;
        A_UNLD_OFF:  unload_off <= unload_off | m;
        A_TRAIN:     run_lane   <= run_lane | m;
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    assert_rot_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rot_rst[i] |=> !rot_rst[i]);
    assert_fifo_clk_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_init[i] |-> !unload_off[i]);
    assert_cal_fw_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      run_cal[i] |-> fw_off[i]);
  end
endmodule

// File: rtl/lane_cal_seq.sv
module lane_cal_seq
  import lcs_pkg::*;
#(
  parameter int LANES = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       seq_sel,
  input  logic [LANES-1:0] lane_mask,
  input  logic [LANES-1:0] lane_busy,
  input  logic [LANES-1:0] cal_done,
  input  logic [LANES-1:0] train_done,
  output logic             seq_busy,
  output logic             seq_done,
  output logic             clk_pdwn,
  output logic [LANES-1:0] run_lane,
  output logic [LANES-1:0] rx_io_rst,
  output logic [LANES-1:0] tx_io_rst,
  output logic [LANES-1:0] rot_rst,
  output logic [LANES-1:0] cfg_load,
  output logic [LANES-1:0] lane_pdwn,
  output logic [LANES-1:0] fw_off,
  output logic [LANES-1:0] run_cal,
  output logic [LANES-1:0] cal_clr,
  output logic [LANES-1:0] unload_off,
  output logic [LANES-1:0] fifo_init,
  output logic [2:0]       cfg_iq_sel,
  output logic [3:0]       cfg_phase_step,
  output logic [2:0]       cfg_inertia,
  output logic [3:0]       cfg_lte,
  output logic [3:0]       cfg_gain
);
  act_e             act;
  logic [LANES-1:0] act_mask;
  logic             any_busy, all_cal, all_train;

  assign cfg_iq_sel     = IQ_SEL_VAL;
  assign cfg_phase_step = PH_STEP_VAL;
  assign cfg_inertia    = INERTIA_VAL;
  assign cfg_lte        = LTE_VAL;
  assign cfg_gain       = GAIN_VAL;

  lcs_mask_reduce #(.LANES(LANES)) u_red (
    .mask(act_mask), .busy_in(lane_busy), .cal_in(cal_done), .train_in(train_done),
    .any_busy(any_busy), .all_cal(all_cal), .all_train(all_train)
  );

  lcs_ctrl #(.LANES(LANES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .seq_sel(seq_sel), .lane_mask(lane_mask),
    .any_busy(any_busy), .all_cal(all_cal), .all_train(all_train),
    .act(act), .act_mask(act_mask), .busy(seq_busy), .done(seq_done)
  );

  lcs_lane_regs #(.LANES(LANES)) u_regs (
    .clk(clk), .rst_n(rst_n), .act(act), .m(act_mask),
    .clk_pdwn(clk_pdwn), .run_lane(run_lane), .rx_io_rst(rx_io_rst),
    .tx_io_rst(tx_io_rst), .rot_rst(rot_rst), .cfg_load(cfg_load),
    .lane_pdwn(lane_pdwn), .fw_off(fw_off), .run_cal(run_cal), .cal_clr(cal_clr),
    .unload_off(unload_off), .fifo_init(fifo_init)
  );

  assert_clk_before_iorst_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|rx_io_rst) |-> !clk_pdwn);
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> !seq_busy);
endmodule

// File: tb/tb_lane_cal_seq.sv
module tb_lane_cal_seq;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] seq_sel = 2'd0;
  logic [LANES-1:0] lane_mask = '0, lane_busy = '0, cal_done = '0, train_done = '0;
  logic seq_busy, seq_done, clk_pdwn;
  logic [LANES-1:0] run_lane, rx_io_rst, tx_io_rst, rot_rst, cfg_load, lane_pdwn;
  logic [LANES-1:0] fw_off, run_cal, cal_clr, unload_off, fifo_init;
  logic [2:0] cfg_iq_sel, cfg_inertia;
  logic [3:0] cfg_phase_step, cfg_lte, cfg_gain;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_cal_seq #(.LANES(LANES)) dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic kick(logic [1:0] sel, logic [LANES-1:0] m);
    @(negedge clk);
    start = 1'b1; seq_sel = sel; lane_mask = m;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic t_reset_state();
    chk("R1 clk_pdwn", {31'd0, clk_pdwn}, 1);
    chk("R1 run_lane", run_lane, 0);
    chk("R1 lane_pdwn", lane_pdwn, 24'hFFFFFF);
    chk("R1 unload_off", unload_off, 24'hFFFFFF);
    chk("R1 strobes", rx_io_rst | tx_io_rst | rot_rst | cfg_load | fw_off | run_cal | cal_clr | fifo_init, 0);
    chk("R1 busy/done", {30'd0, seq_busy, seq_done}, 0);
  endtask

  task automatic t_empty_and_bad();
    kick(2'd0, '0);
    chk("R11 empty done", {30'd0, seq_busy, seq_done}, 1);
    chk("R11 empty clk_pdwn kept", {31'd0, clk_pdwn}, 1);
    @(negedge clk);
    chk("R10 done single", {31'd0, seq_done}, 0);
  endtask

  task automatic t_train();
    train_done = 24'h0000F0;
    kick(2'd2, 24'h0000FF);
    chk("R9 run_lane set", run_lane, 24'h0000FF);
    chk("R10 busy", {31'd0, seq_busy}, 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9 waiting", {30'd0, seq_busy, seq_done}, 2);
    end
    train_done = 24'h0000FF;
    @(negedge clk);
    chk("R9 not yet done", {31'd0, seq_done}, 0);
    @(negedge clk);
    chk("R9 done", {30'd0, seq_busy, seq_done}, 1);
  endtask

  task automatic t_lane_reset();
    lane_busy = 24'h000006;
    kick(2'd0, 24'h0000A5);
    chk("R2 clk on", {31'd0, clk_pdwn}, 0);
    chk("R2 run_lane masked clear", run_lane, 24'h00005A);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R3 held by busy", rx_io_rst | tx_io_rst, 0);
    end
    lane_busy = 24'h000002;
    @(negedge clk);
    chk("R4 rx io reset", rx_io_rst, 24'h0000A5);
    chk("R4 tx io reset", tx_io_rst, 24'h0000A5);
    chk("R3 unmasked busy ignored", {31'd0, seq_busy}, 1);
    @(negedge clk);
    chk("R4 io release", rx_io_rst | tx_io_rst | rot_rst, 0);
    @(negedge clk);
    chk("R4 rot pulse", rot_rst, 24'h0000A5);
    @(negedge clk);
    chk("R4 rot low", rot_rst, 0);
    chk("R5 cfg_load", cfg_load, 24'h0000A5);
    chk("R5 lane_pdwn", lane_pdwn, 24'hFFFF5A);
    chk("R5 values", {cfg_iq_sel, cfg_phase_step, cfg_inertia, cfg_lte, cfg_gain}, {3'd7, 4'hC, 3'd4, 4'd3, 4'd11});
    @(negedge clk);
    chk("R5 cfg_load single", cfg_load, 0);
    chk("R10 done", {30'd0, seq_busy, seq_done}, 1);
    lane_busy = '0;
  endtask

  task automatic t_dccal();
    cal_done = 24'h000021;
    kick(2'd1, 24'h800001);
    lane_mask = 24'hFFFFFF;
    chk("R6 fw_off", fw_off, 24'h800001);
    chk("R6 run_cal not yet", run_cal, 0);
    @(negedge clk);
    chk("R6 run_cal", run_cal, 24'h800001);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk("R6 waiting all done", run_cal, 24'h800001);
    end
    cal_done = 24'h800001;
    @(negedge clk);
    chk("R7 run_cal cleared", run_cal, 0);
    chk("R7 fw still off", fw_off, 24'h800001);
    @(negedge clk);
    chk("R7 cal_clr", cal_clr, 24'h800001);
    chk("R7 fw cleared", fw_off, 0);
    @(negedge clk);
    chk("R8 unload on", unload_off, 24'h7FFFFE);
    chk("R12 mask captured", cal_clr, 0);
    @(negedge clk);
    chk("R8 fifo_init", fifo_init, 24'h800001);
    @(negedge clk);
    chk("R8 fifo low", fifo_init, 0);
    chk("R8 unload off again", unload_off, 24'hFFFFFF);
    @(negedge clk);
    chk("R10 dccal done", {30'd0, seq_busy, seq_done}, 1);
    cal_done = '0;
  endtask

  task automatic t_start_busy();
    train_done = '0;
    kick(2'd2, 24'h000001);
    chk("R9 run_lane", run_lane, 24'h00005B);
    kick(2'd0, 24'hFFFFFF);
    for (int i = 0; i < 3; i++) begin
      chk("R12 second start ignored", run_lane | rx_io_rst, 24'h00005B);
      @(negedge clk);
    end
    train_done = 24'h000001;
    @(negedge clk);
    @(negedge clk);
    chk("R12 original finishes", {30'd0, seq_busy, seq_done}, 1);
    kick(2'd3, 24'hFFFFFF);
    chk("R11 sel 3 done", {30'd0, seq_busy, seq_done}, 1);
    chk("R11 sel 3 no change", run_lane | rx_io_rst | fw_off, 24'h00005B);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_empty_and_bad();
    t_train();
    t_lane_reset();
    t_dccal();
    t_start_busy();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule